// File: doc/BRIEF.md
# Saturating Clear-on-Read Filter Event Counter

This block counts events from a receive cell filter. Each cycle the filter may raise a discard strobe, a copy strobe (the cell is copied to an extraction buffer), or both. A two-bit mode input chooses which of these events advance the count. The count is kept in a wide register, 32 bits by default, that stops at all-ones and does not wrap.

Software reads the count over a narrow register bus, one byte at a time, with a simple read strobe and a byte address. Reading the most significant byte does three things in the same cycle: it returns that byte, it copies the whole live count into a snapshot register, and it clears the live count. Reads of the lower bytes then return bytes of the snapshot. The bytes of one value therefore always belong together, and each value read is the number of events since the previous clearing read.

Top module: `evcnt_top`

## Requirements
- R1: After reset the live count, the snapshot and `rdData` are all zero.
- R2: With `mode` = 2'b01, each cycle with `discardEv` high adds one to the count, and `copyEv` is ignored.
- R3: With `mode` = 2'b10, each cycle with `copyEv` high adds one to the count, and `discardEv` is ignored.
- R4: With `mode` = 2'b11, each cycle with `discardEv` or `copyEv` high adds one. A cycle with both high adds exactly one.
- R5: With `mode` = 2'b00, no event changes the count.
- R6: The count bytes sit at consecutive addresses. The most significant byte is at `BASE_ADDR` and the least significant byte is at `BASE_ADDR + NUM_BYTES - 1` (defaults: 4 and 7). `rdData` is registered and is valid on the cycle after the cycle in which `rdEn` is high. It is zero in any cycle that follows no hitting read.
- R7: A read of the most significant byte returns that byte of the live count, loads the full live count into the snapshot, and clears the live count. Reads of the lower bytes return the matching snapshot byte and do not clear anything.
- R8: An event that counts in the same cycle as a clearing read leaves the live count at 1. That event is not part of the snapshot.
- R9: Once the count is all-ones it stays all-ones under further events until a clearing read.
- R10: A read at an address outside the count range returns zero and leaves the count and the snapshot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Selects which events count: 00 none, 01 discard, 10 copy, 11 either |
| discardEv | input | 1 | A cell was discarded in this cycle |
| copyEv | input | 1 | A cell was copied to the extraction buffer in this cycle |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdData | output | BUS_W | Registered read data |

## Verification
A wrong live count becomes visible only at the next clearing read, so every scenario ends by reading all bytes and comparing the whole value, with the most significant byte read first. If the snapshot is wrong or is updated at the wrong time, a lower-byte read returns a byte that does not match the value just cleared; one scenario counts more events between the clearing read and the lower-byte reads to expose this. Wrapping instead of saturating, or losing the event that collides with a read, shows up one read later as a wrong small number. A smaller second instance is used so that saturation can be reached in a short run.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_DISCARD = 2'b01,
    MODE_COPY    = 2'b10,
    MODE_EITHER  = 2'b11
  } cntMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incr;   // one countable event this cycle
    logic clear;  // MSB read: snapshot and clear
    logic rdHit;  // read address inside the count range
  } ctrlStrb_t;

endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_BYTES = 4,
  parameter int BASE_ADDR = 4,
  parameter int IDX_W     = 2
) (
  input  logic [1:0]        mode,
  input  logic              discardEv,
  input  logic              copyEv,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrb_t         strb,
  output logic [IDX_W-1:0]  byteIdx
);

  localparam logic [ADDR_W:0]  LO_ADDR  = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0]  HI_ADDR  = (ADDR_W+1)'(BASE_ADDR + NUM_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic              eventHit;
  logic              inRange;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    unique case (cntMode_e'(mode))
      MODE_DISCARD: eventHit = discardEv;
      MODE_COPY:    eventHit = copyEv;
      MODE_EITHER:  eventHit = discardEv | copyEv;
      default:      eventHit = 1'b0;
    endcase
  end

  always_comb begin
    inRange = ({1'b0, rdAddr} >= LO_ADDR) && ({1'b0, rdAddr} < HI_ADDR);
    offset  = rdAddr - ADDR_W'(BASE_ADDR);
    byteIdx = LAST_IDX - offset[IDX_W-1:0];
  end

  always_comb begin
    strb.incr  = eventHit;
    strb.rdHit = rdEn && inRange;
    strb.clear = rdEn && inRange && (offset == '0);
  end

endmodule

// File: rtl/evcnt_dp.sv
module evcnt_dp
  import evcnt_pkg::*;
#(
  parameter int COUNT_W   = 32,
  parameter int BUS_W     = 8,
  parameter int NUM_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrb_t          strb,
  input  logic [IDX_W-1:0]   byteIdx,
  output logic [BUS_W-1:0]   rdData,
  output logic [COUNT_W-1:0] liveCnt,
  output logic [COUNT_W-1:0] snapCnt
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  logic [BUS_W-1:0] snapBytes [NUM_BYTES];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_slice
    assign snapBytes[b] = snapCnt[b*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveCnt <= '0;
      snapCnt <= '0;
    end else if (strb.clear) begin
      snapCnt <= liveCnt;
      liveCnt <= strb.incr ? CNT_ONE : '0;
    end else if (strb.incr && (liveCnt != CNT_MAX)) begin
      liveCnt <= liveCnt + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.clear) begin
      rdData <= liveCnt[COUNT_W-1 -: BUS_W];
    end else if (strb.rdHit) begin
      rdData <= snapBytes[byteIdx];
    end else begin
      rdData <= '0;
    end
  end

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
  import evcnt_pkg::*;
#(
  parameter int COUNT_W   = 32,
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              discardEv,
  input  logic              copyEv,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData
);

  localparam int NUM_BYTES = COUNT_W / BUS_W;
  localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  ctrlStrb_t          strb;
  logic [IDX_W-1:0]   byteIdx;
  logic [COUNT_W-1:0] liveCnt;
  logic [COUNT_W-1:0] snapCnt;

  evcnt_ctrl #(
    .ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)
  ) u_ctrl (
    .mode(mode), .discardEv(discardEv), .copyEv(copyEv),
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb), .byteIdx(byteIdx)
  );

  evcnt_dp #(
    .COUNT_W(COUNT_W), .BUS_W(BUS_W), .NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .byteIdx(byteIdx),
    .rdData(rdData), .liveCnt(liveCnt), .snapCnt(snapCnt)
  );

endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int COUNT_W   = 32,
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         mode,
  input logic               discardEv,
  input logic               copyEv,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [BUS_W-1:0]   rdData,
  input logic [COUNT_W-1:0] liveCnt,
  input logic [COUNT_W-1:0] snapCnt
);

  localparam int NUM_BYTES = COUNT_W / BUS_W;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic msbRd;
  logic addrOk;
  logic evIn;

  always_comb begin
    msbRd  = rdEn && (rdAddr == ADDR_W'(BASE_ADDR));
    addrOk = (int'(rdAddr) >= BASE_ADDR) && (int'(rdAddr) < BASE_ADDR + NUM_BYTES);
    evIn   = (mode[0] && discardEv) || (mode[1] && copyEv);
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (liveCnt == CNT_MAX && !msbRd) |=> liveCnt == CNT_MAX);

  // R7
  snap_load_chk: assert property (@(posedge clk) disable iff (rst)
    msbRd |=> snapCnt == $past(liveCnt));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    msbRd |=> liveCnt == COUNT_W'($past(evIn)));

  // R5
  idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !msbRd) |=> $stable(liveCnt));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evIn && !msbRd && liveCnt != CNT_MAX) |=> liveCnt == $past(liveCnt) + COUNT_W'(1));

  // R10
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !addrOk) |=> (rdData == '0 && $stable(snapCnt)));

endmodule

bind evcnt_top evcnt_chk #(
  .COUNT_W(COUNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .discardEv(discardEv), .copyEv(copyEv),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .liveCnt(liveCnt), .snapCnt(snapCnt)
);

// File: tb/evcnt_top_tb.sv
module evcnt_top_tb;

  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       discardEv = 1'b0;
  logic       copyEv = 1'b0;
  logic       rdEn = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [7:0] rdData;

  logic [1:0] sMode = 2'b00;
  logic       sDiscard = 1'b0;
  logic       sRdEn = 1'b0;
  logic [3:0] sRdAddr = '0;
  logic [7:0] sRdData;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  evcnt_top u_dut (
    .clk(clk), .rst(rst), .mode(mode), .discardEv(discardEv), .copyEv(copyEv),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  // 16-bit instance so that saturation is reachable
  evcnt_top #(.COUNT_W(16)) u_sat (
    .clk(clk), .rst(rst), .mode(sMode), .discardEv(sDiscard), .copyEv(1'b0),
    .rdEn(sRdEn), .rdAddr(sRdAddr), .rdData(sRdData)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic readByte(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic readCount(output logic [31:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 4; i++) begin
      readByte(4'(BASE + i), b);
      v = {v[23:0], b};
    end
  endtask

  task automatic pulse(input logic d, input logic c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      discardEv = d; copyEv = c;
    end
    @(negedge clk);
    discardEv = 1'b0; copyEv = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdData after reset", 32'(rdData), 32'h0);
    readCount(v);
    check("R1 count after reset", v, 32'h0);
  endtask

  task automatic t_discard();
    logic [31:0] v;
    mode = 2'b01;
    pulse(1'b1, 1'b0, 5);
    pulse(1'b0, 1'b1, 3);
    readCount(v);
    check("R2 discard mode count", v, 32'd5);
    pulse(1'b1, 1'b1, 7);
    readCount(v);
    check("R2 back-to-back discards", v, 32'd7);
  endtask

  task automatic t_copy();
    logic [31:0] v;
    mode = 2'b10;
    pulse(1'b0, 1'b1, 4);
    pulse(1'b1, 1'b0, 2);
    readCount(v);
    check("R3 copy mode count", v, 32'd4);
  endtask

  task automatic t_either();
    logic [31:0] v;
    mode = 2'b11;
    pulse(1'b1, 1'b0, 2);
    pulse(1'b0, 1'b1, 3);
    pulse(1'b1, 1'b1, 4);
    readCount(v);
    check("R4 either mode, both counts one", v, 32'd9);
  endtask

  task automatic t_off();
    logic [31:0] v;
    mode = 2'b00;
    pulse(1'b1, 1'b1, 6);
    readCount(v);
    check("R5 mode off counts nothing", v, 32'd0);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    logic [7:0]  b;
    mode = 2'b01;
    pulse(1'b1, 1'b0, 300);
    readByte(4'(BASE), b);
    check("R7 MSB of 0x12c", 32'(b), 32'h0);
    @(negedge clk);
    check("R6 rdData zero without read", 32'(rdData), 32'h0);
    pulse(1'b1, 1'b0, 5);
    readByte(4'(BASE + 2), b);
    check("R6 byte at BASE+2 from snapshot", 32'(b), 32'h01);
    readByte(4'(BASE + 3), b);
    check("R7 LSB from snapshot not live", 32'(b), 32'h2c);
    readCount(v);
    check("R7 live after clear", v, 32'd5);
    readCount(v);
    check("R7 second read is zero", v, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    logic [7:0]  b;
    mode = 2'b01;
    pulse(1'b1, 1'b0, 2);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 4'(BASE); discardEv = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; discardEv = 1'b0;
    check("R8 MSB on colliding read", 32'(rdData), 32'h0);
    readByte(4'(BASE + 3), b);
    check("R8 snapshot excludes colliding event", 32'(b), 32'd2);
    readCount(v);
    check("R8 colliding event kept", v, 32'd1);
  endtask

  task automatic t_badaddr();
    logic [31:0] v;
    logic [7:0]  b;
    mode = 2'b01;
    pulse(1'b1, 1'b0, 4);
    readByte(4'h0, b);
    check("R10 low address reads zero", 32'(b), 32'h0);
    readByte(4'(BASE + 4), b);
    check("R10 high address reads zero", 32'(b), 32'h0);
    readCount(v);
    check("R10 count untouched", v, 32'd4);
  endtask

  task automatic t_saturate();
    logic [7:0] hi;
    logic [7:0] lo;
    sMode = 2'b01;
    @(negedge clk);
    sDiscard = 1'b1;
    repeat (65540) @(negedge clk);
    sDiscard = 1'b0;
    sRdEn = 1'b1; sRdAddr = 4'(BASE);
    @(negedge clk);
    hi = sRdData;
    sRdAddr = 4'(BASE + 1);
    @(negedge clk);
    sRdEn = 1'b0;
    lo = sRdData;
    check("R9 saturated value", {16'h0, hi, lo}, 32'h0000ffff);
    @(negedge clk);
    sDiscard = 1'b1;
    @(negedge clk);
    sDiscard = 1'b0;
    sRdEn = 1'b1; sRdAddr = 4'(BASE);
    @(negedge clk);
    sRdAddr = 4'(BASE + 1);
    @(negedge clk);
    sRdEn = 1'b0;
    check("R9 restarts after clear", 32'(sRdData), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_discard();
    t_copy();
    t_either();
    t_off();
    t_snapshot();
    t_collide();
    t_badaddr();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule